// File: doc/BRIEF.md
# Rotating register rename unit

This block turns a virtual register number into a physical register number for three register files: general (128 entries), floating-point (128 entries) and predicate (64 entries). The lower part of each file is never renamed. In the upper part, the rotating region, the physical index is the virtual index shifted by a per-class rotation base, and the result wraps modulo the size of the region. The floating-point region covers entries 32 to 127. The predicate region covers entries 16 to 63. The general region starts at entry 32, and its size is set at run time in groups of eight registers.

Several independent combinational lookup ports share one rotation-base counter per class. A rotate strobe steps all three counters down by one in a single cycle, each modulo its own region size. A clear strobe zeroes all three counters and takes priority over a rotate in the same cycle. Each port also flags the hardwired entries: the zero general register, the two constant floating-point registers and the always-true predicate. These pass through with their index unchanged. The register storage itself lies outside this block.

Top module: `rot_rename`

## Requirements
- R1: A virtual index below the start of its class's rotating region (32 for general and floating-point, 16 for predicate) appears unchanged on `pidx_o`.
- R2: For class code 1 (floating-point) and a virtual index v in 32..127, `pidx_o` = 32 + ((v − 32 + rrb_fr) mod 96).
- R3: For class code 2 (predicate) and v in 16..63, `pidx_o` = 16 + ((v − 16 + rrb_pr) mod 48). A predicate index of 64 or more passes through unchanged.
- R4: For class code 0 (general), the region size is S = 8 × min(`gr_grp_i`, 12). For v in 32..32+S−1, `pidx_o` = 32 + ((v − 32 + rrb_gr) mod S). For v ≥ 32+S, and for every v when S = 0, the index passes through unchanged.
- R5: A rotate strobe without clear lowers each rotation base by one at the next clock edge. A base of 0 wraps to its region size minus one (95, 47, S−1). The general base stays at 0 while S = 0.
- R6: A clear strobe sets all three rotation bases to 0 at the next clock edge, even if a rotate is asserted in the same cycle.
- R7: With neither strobe asserted, all three rotation bases keep their values.
- R8: While reset is asserted, and right after it is released, all three rotation bases read 0.
- R9: `fixed_o` is high, and `pidx_o` equals `vidx_i`, for general index 0, floating-point index 0 or 1, and predicate index 0. It is low for every other index of those classes.
- R10: Class code 3 is reserved. Any index passes through unchanged and `fixed_o` is low.
- R11: Each lookup port translates its own class and index independently of the other ports, and all ports use the same rotation bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rot_i | input | 1 | Rotate strobe: decrement all rotation bases |
| clr_i | input | 1 | Clear strobe: zero all rotation bases |
| gr_grp_i | input | 4 | General rotating region size in groups of eight (values above 12 are treated as 12) |
| cls_i | input | NUM_PORTS×2 | Per-port register class: 0 general, 1 floating-point, 2 predicate, 3 reserved |
| vidx_i | input | NUM_PORTS×7 | Per-port virtual register index |
| pidx_o | output | NUM_PORTS×7 | Per-port physical register index |
| fixed_o | output | NUM_PORTS | Per-port flag for a hardwired constant register |
| rrb_gr_o | output | 7 | General rotation base |
| rrb_fr_o | output | 7 | Floating-point rotation base |
| rrb_pr_o | output | 7 | Predicate rotation base |

## Verification
The counter properties assume that `gr_grp_i` changes only in a cycle where `clr_i` is also asserted, so the general rotation base never exceeds the current region size. The bench therefore sets a new group count together with a clear pulse, and only then issues rotate pulses. The lookup properties assume a valid class code and a known index on every port. The bench drives both ports from the first cycle onward.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    CLS_GR  = 2'd0,
    CLS_FR  = 2'd1,
    CLS_PR  = 2'd2,
    CLS_RSV = 2'd3
  } reg_cls_e;
endpackage

// File: rtl/rrb_counter.sv
module rrb_counter #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rot_i,
  input  logic [W:0]   size_i,
  output logic [W-1:0] rrb_o
);
  logic [W-1:0] top_idx;
  assign top_idx = W'(size_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrb_o <= '0;
    end else if (clr_i) begin
      rrb_o <= '0;
    end else if (rot_i) begin
      if (size_i == '0)      rrb_o <= '0;
      else if (rrb_o == '0)  rrb_o <= top_idx;
      else                   rrb_o <= rrb_o - 1'b1;
    end
  end
endmodule

// File: rtl/rot_lookup.sv
module rot_lookup #(
  parameter int W    = 7,
  parameter int BASE = 32
) (
  input  logic [W-1:0] vidx_i,
  input  logic [W-1:0] rrb_i,
  input  logic [W:0]   size_i,
  output logic [W-1:0] pidx_o,
  output logic         in_rgn_o
);
  localparam logic [W:0]   BASE_X = (W+1)'(BASE);
  localparam logic [W-1:0] BASE_N = W'(BASE);

  logic [W:0]   v_x, top, rel, sum;
  logic [W-1:0] wrap, phys;

  assign v_x      = {1'b0, vidx_i};
  assign top      = BASE_X + size_i;
  assign in_rgn_o = (size_i != '0) && (v_x >= BASE_X) && (v_x < top);
  assign rel      = v_x - BASE_X;
  assign sum      = rel + {1'b0, rrb_i};
  // one conditional subtract suffices: rel < size and rrb < size
  assign wrap     = (sum >= size_i) ? W'(sum - size_i) : W'(sum);
  assign phys     = BASE_N + wrap;
  assign pidx_o   = in_rgn_o ? phys : vidx_i;
endmodule

// File: rtl/rot_port.sv
module rot_port
  import rot_pkg::*;
#(
  parameter int W       = 7,
  parameter int GR_BASE = 32,
  parameter int FR_BASE = 32,
  parameter int PR_BASE = 16
) (
  input  logic [1:0]   cls_i,
  input  logic [W-1:0] vidx_i,
  input  logic [W-1:0] rrb_gr_i,
  input  logic [W-1:0] rrb_fr_i,
  input  logic [W-1:0] rrb_pr_i,
  input  logic [W:0]   gr_sz_i,
  input  logic [W:0]   fr_sz_i,
  input  logic [W:0]   pr_sz_i,
  output logic [W-1:0] pidx_o,
  output logic         fixed_o
);
  logic [W-1:0] p_gr, p_fr, p_pr;
  logic         h_gr, h_fr, h_pr;
  reg_cls_e     cls;

  assign cls = reg_cls_e'(cls_i);

  rot_lookup #(.W(W), .BASE(GR_BASE)) i_gr (
    .vidx_i(vidx_i), .rrb_i(rrb_gr_i), .size_i(gr_sz_i),
    .pidx_o(p_gr), .in_rgn_o(h_gr));
  rot_lookup #(.W(W), .BASE(FR_BASE)) i_fr (
    .vidx_i(vidx_i), .rrb_i(rrb_fr_i), .size_i(fr_sz_i),
    .pidx_o(p_fr), .in_rgn_o(h_fr));
  rot_lookup #(.W(W), .BASE(PR_BASE)) i_pr (
    .vidx_i(vidx_i), .rrb_i(rrb_pr_i), .size_i(pr_sz_i),
    .pidx_o(p_pr), .in_rgn_o(h_pr));

  always_comb begin
    pidx_o  = vidx_i;
    fixed_o = 1'b0;
    unique case (cls)
      CLS_GR: begin
        pidx_o  = p_gr;
        fixed_o = (vidx_i == '0) && !h_gr;
      end
      CLS_FR: begin
        pidx_o  = p_fr;
        fixed_o = (vidx_i <= W'(1)) && !h_fr;
      end
      CLS_PR: begin
        pidx_o  = p_pr;
        fixed_o = (vidx_i == '0) && !h_pr;
      end
      default: begin
        pidx_o  = vidx_i;
        fixed_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rot_rename.sv
module rot_rename #(
  parameter int NUM_PORTS = 2,
  parameter int N_GR      = 128,
  parameter int N_FR      = 128,
  parameter int N_PR      = 64,
  parameter int GR_BASE   = 32,
  parameter int FR_BASE   = 32,
  parameter int PR_BASE   = 16,
  parameter int GRP       = 8,
  localparam int IDX_W    = $clog2(N_GR),
  localparam int MAX_GRP  = (N_GR - GR_BASE) / GRP,
  localparam int GSZ_W    = $clog2(MAX_GRP + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            rot_i,
  input  logic                            clr_i,
  input  logic [GSZ_W-1:0]                gr_grp_i,
  input  logic [NUM_PORTS-1:0][1:0]       cls_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] vidx_i,
  output logic [NUM_PORTS-1:0][IDX_W-1:0] pidx_o,
  output logic [NUM_PORTS-1:0]            fixed_o,
  output logic [IDX_W-1:0]                rrb_gr_o,
  output logic [IDX_W-1:0]                rrb_fr_o,
  output logic [IDX_W-1:0]                rrb_pr_o
);
  localparam logic [IDX_W:0]   FR_SZ  = (IDX_W+1)'(N_FR - FR_BASE);
  localparam logic [IDX_W:0]   PR_SZ  = (IDX_W+1)'(N_PR - PR_BASE);
  localparam logic [GSZ_W-1:0] MAX_GN = GSZ_W'(MAX_GRP);

  logic [GSZ_W-1:0] grp_c;
  logic [IDX_W:0]   gr_sz;

  assign grp_c = (gr_grp_i > MAX_GN) ? MAX_GN : gr_grp_i;
  assign gr_sz = (IDX_W+1)'(int'(grp_c) * GRP);

  rrb_counter #(.W(IDX_W)) i_rrb_gr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .rot_i(rot_i),
    .size_i(gr_sz), .rrb_o(rrb_gr_o));
  rrb_counter #(.W(IDX_W)) i_rrb_fr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .rot_i(rot_i),
    .size_i(FR_SZ), .rrb_o(rrb_fr_o));
  rrb_counter #(.W(IDX_W)) i_rrb_pr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .rot_i(rot_i),
    .size_i(PR_SZ), .rrb_o(rrb_pr_o));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rot_port #(
      .W(IDX_W), .GR_BASE(GR_BASE), .FR_BASE(FR_BASE), .PR_BASE(PR_BASE)
    ) i_port (
      .cls_i   (cls_i[p]),
      .vidx_i  (vidx_i[p]),
      .rrb_gr_i(rrb_gr_o),
      .rrb_fr_i(rrb_fr_o),
      .rrb_pr_i(rrb_pr_o),
      .gr_sz_i (gr_sz),
      .fr_sz_i (FR_SZ),
      .pr_sz_i (PR_SZ),
      .pidx_o  (pidx_o[p]),
      .fixed_o (fixed_o[p])
    );
  end
endmodule

// File: rtl/rot_rename_chk.sv
module rot_rename_chk #(
  parameter int NUM_PORTS = 2,
  parameter int N_GR      = 128,
  parameter int N_FR      = 128,
  parameter int N_PR      = 64,
  parameter int GR_BASE   = 32,
  parameter int FR_BASE   = 32,
  parameter int PR_BASE   = 16,
  parameter int GRP       = 8,
  localparam int IDX_W    = $clog2(N_GR),
  localparam int MAX_GRP  = (N_GR - GR_BASE) / GRP,
  localparam int GSZ_W    = $clog2(MAX_GRP + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            rot_i,
  input logic                            clr_i,
  input logic [GSZ_W-1:0]                gr_grp_i,
  input logic [NUM_PORTS-1:0][1:0]       cls_i,
  input logic [NUM_PORTS-1:0][IDX_W-1:0] vidx_i,
  input logic [NUM_PORTS-1:0][IDX_W-1:0] pidx_o,
  input logic [NUM_PORTS-1:0]            fixed_o,
  input logic [IDX_W-1:0]                rrb_gr_o,
  input logic [IDX_W-1:0]                rrb_fr_o,
  input logic [IDX_W-1:0]                rrb_pr_o
);
  int gsz;
  assign gsz = ((int'(gr_grp_i) > MAX_GRP) ? MAX_GRP : int'(gr_grp_i)) * GRP;

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rrb_gr_o == '0) && (rrb_fr_o == '0) && (rrb_pr_o == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_i && !clr_i) |=> $stable(rrb_gr_o) && $stable(rrb_fr_o) && $stable(rrb_pr_o));

  assert_fr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && !clr_i) |=> int'(rrb_fr_o) ==
      (($past(rrb_fr_o) == '0) ? (N_FR - FR_BASE - 1) : int'($past(rrb_fr_o)) - 1));

  assert_pr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && !clr_i) |=> int'(rrb_pr_o) ==
      (($past(rrb_pr_o) == '0) ? (N_PR - PR_BASE - 1) : int'($past(rrb_pr_o)) - 1));

  assert_gr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && !clr_i) |=> int'(rrb_gr_o) ==
      (($past(gsz) == 0) ? 0 :
       (($past(rrb_gr_o) == '0) ? $past(gsz) - 1 : int'($past(rrb_gr_o)) - 1)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_low_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(vidx_i[p]) < PR_BASE) |-> (pidx_o[p] == vidx_i[p]));

    assert_fr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cls_i[p] == 2'd1 && int'(vidx_i[p]) >= FR_BASE) |-> (int'(pidx_o[p]) >= FR_BASE));

    assert_pr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cls_i[p] == 2'd2 && int'(vidx_i[p]) >= PR_BASE && int'(vidx_i[p]) < N_PR)
        |-> (int'(pidx_o[p]) >= PR_BASE && int'(pidx_o[p]) < N_PR));

    assert_fixed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fixed_o[p] |-> (pidx_o[p] == vidx_i[p]) && (int'(vidx_i[p]) < 2));

    assert_rsv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cls_i[p] == 2'd3) |-> (pidx_o[p] == vidx_i[p]) && !fixed_o[p]);
  end
endmodule

bind rot_rename rot_rename_chk #(
  .NUM_PORTS(NUM_PORTS), .N_GR(N_GR), .N_FR(N_FR), .N_PR(N_PR),
  .GR_BASE(GR_BASE), .FR_BASE(FR_BASE), .PR_BASE(PR_BASE), .GRP(GRP)
) i_rot_rename_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rot_i(rot_i), .clr_i(clr_i),
  .gr_grp_i(gr_grp_i), .cls_i(cls_i), .vidx_i(vidx_i), .pidx_o(pidx_o),
  .fixed_o(fixed_o), .rrb_gr_o(rrb_gr_o), .rrb_fr_o(rrb_fr_o), .rrb_pr_o(rrb_pr_o)
);

// File: tb/test_rot_rename.sv
module test_rot_rename;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rot = 1'b0, clr = 1'b0;
  logic [3:0]       grp = 4'd12;
  logic [1:0][1:0]  cls = '0;
  logic [1:0][6:0]  vidx = '0;
  logic [1:0][6:0]  pidx;
  logic [1:0]       fixd;
  logic [6:0]       rrb_gr, rrb_fr, rrb_pr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rot_rename i_rot_rename (
    .clk_i(clk), .rst_ni(rst_n), .rot_i(rot), .clr_i(clr), .gr_grp_i(grp),
    .cls_i(cls), .vidx_i(vidx), .pidx_o(pidx), .fixed_o(fixd),
    .rrb_gr_o(rrb_gr), .rrb_fr_o(rrb_fr), .rrb_pr_o(rrb_pr));

  typedef struct packed {
    logic [7:0] nrot;
    logic [3:0] g;
    logic [1:0] c;
    logic [6:0] v;
    logic [6:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [0:15] = '{
    '{8'd0, 4'd12, 2'd0, 7'd40,  7'd40,  4'd4},
    '{8'd1, 4'd12, 2'd0, 7'd32,  7'd127, 4'd4},
    '{8'd1, 4'd12, 2'd0, 7'd33,  7'd32,  4'd4},
    '{8'd3, 4'd2,  2'd0, 7'd40,  7'd37,  4'd4},
    '{8'd3, 4'd2,  2'd0, 7'd48,  7'd48,  4'd4},
    '{8'd3, 4'd2,  2'd0, 7'd20,  7'd20,  4'd1},
    '{8'd2, 4'd12, 2'd1, 7'd32,  7'd126, 4'd2},
    '{8'd2, 4'd12, 2'd1, 7'd127, 7'd125, 4'd2},
    '{8'd5, 4'd12, 2'd2, 7'd16,  7'd59,  4'd3},
    '{8'd5, 4'd12, 2'd2, 7'd63,  7'd58,  4'd3},
    '{8'd5, 4'd12, 2'd2, 7'd15,  7'd15,  4'd1},
    '{8'd5, 4'd12, 2'd2, 7'd70,  7'd70,  4'd3},
    '{8'd4, 4'd0,  2'd0, 7'd40,  7'd40,  4'd4},
    '{8'd1, 4'd15, 2'd0, 7'd32,  7'd127, 4'd4},
    '{8'd2, 4'd12, 2'd3, 7'd50,  7'd50,  4'd10},
    '{8'd1, 4'd1,  2'd0, 7'd39,  7'd38,  4'd4}
  };

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic pulse_clr(input logic with_rot);
    @(negedge clk); clr = 1'b1; rot = with_rot;
    @(negedge clk); clr = 1'b0; rot = 1'b0;
  endtask

  task automatic rotate(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rot = 1'b1;
    end
    @(negedge clk); rot = 1'b0;
  endtask

  task automatic look(input int p, input logic [1:0] c, input logic [6:0] v);
    cls[p] = c; vidx[p] = v;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk);
    chk("R8 gr in reset", int'(rrb_gr), 0);
    chk("R8 fr in reset", int'(rrb_fr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 pr after reset", int'(rrb_pr), 0);

    // table walk: R1 R2 R3 R4 R10
    foreach (VEC[i]) begin
      @(negedge clk); grp = VEC[i].g; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      if (VEC[i].nrot != 0) rotate(int'(VEC[i].nrot));
      look(0, VEC[i].c, VEC[i].v);
      look(1, 2'd0, 7'd0);
      #5;
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), int'(pidx[0]), int'(VEC[i].exp));
    end

    // R5: wrap from zero on each class
    grp = 4'd12;
    pulse_clr(1'b0);
    rotate(1);
    #5;
    chk("R5 gr wrap", int'(rrb_gr), 95);
    chk("R5 fr wrap", int'(rrb_fr), 95);
    chk("R5 pr wrap", int'(rrb_pr), 47);
    rotate(1);
    #5;
    chk("R5 fr step", int'(rrb_fr), 94);
    chk("R5 pr step", int'(rrb_pr), 46);

    // R7: idle holds
    repeat (3) @(negedge clk);
    chk("R7 gr hold", int'(rrb_gr), 94);
    chk("R7 fr hold", int'(rrb_fr), 94);
    chk("R7 pr hold", int'(rrb_pr), 46);

    // R11: two ports at once with rrb_gr=94, rrb_pr=46
    look(0, 2'd0, 7'd33);
    look(1, 2'd2, 7'd16);
    #5;
    chk("R11 port0 gr", int'(pidx[0]), 32 + ((1 + 94) % 96));
    chk("R11 port1 pr", int'(pidx[1]), 16 + ((0 + 46) % 48));

    // R6: clear beats rotate
    pulse_clr(1'b1);
    #5;
    chk("R6 gr cleared", int'(rrb_gr), 0);
    chk("R6 fr cleared", int'(rrb_fr), 0);
    chk("R6 pr cleared", int'(rrb_pr), 0);

    // R5: general base stays 0 with empty region
    @(negedge clk); grp = 4'd0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    rotate(2);
    #5;
    chk("R5 gr empty region", int'(rrb_gr), 0);
    chk("R5 fr with empty gr", int'(rrb_fr), 94);

    // R9 / R10: hardwired entries
    look(0, 2'd0, 7'd0); look(1, 2'd1, 7'd1);
    #5;
    chk("R9 r0 fixed", int'(fixd[0]), 1);
    chk("R9 f1 fixed", int'(fixd[1]), 1);
    chk("R9 f1 index", int'(pidx[1]), 1);
    look(0, 2'd2, 7'd0); look(1, 2'd1, 7'd2);
    #5;
    chk("R9 p0 fixed", int'(fixd[0]), 1);
    chk("R9 f2 not fixed", int'(fixd[1]), 0);
    look(0, 2'd3, 7'd0); look(1, 2'd0, 7'd1);
    #5;
    chk("R10 rsv not fixed", int'(fixd[0]), 0);
    chk("R9 r1 not fixed", int'(fixd[1]), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule